// File: doc/BRIEF.md
# Four-Beat Burst Address Sequencer

This block produces the two least significant address bits for a four-beat burst. It is meant to sit in front of a synchronous memory array. A burst opens when either of two independent address strobes is seen at a rising clock edge. At that edge the block captures the low two bits of the external address as the starting point. Each later cycle with the advance input high moves the sequence one beat forward.

Two orderings are supported, and a mode input picks between them. The interleaved order combines the start address and the beat count with an exclusive OR. The linear order adds the beat count to the start address modulo four. The upper address bits are not sequenced. They reach the output unchanged and without delay. The block also reports which beat is current and flags the final beat of the group of four.

Top module: `burst_seq`

## Requirements
- R1: While `rst_n` is low, and after it is released, `beat` is 0, `burst_lo` is 0 and `last_beat` is 0 until the first strobe or advance.
- R2: When `strobe_cpu` or `strobe_ctl` is high at a rising edge, the next cycle shows `beat` = 0 and `burst_lo` equal to the `start_lo` value sampled at that edge. Either strobe alone, or both together, has this effect.
- R3: When no strobe and `advance` are high at a rising edge, `beat` increments by one modulo 4.
- R4: A strobe takes priority over `advance` in the same cycle, so the sequence restarts at beat 0 from the new start value.
- R5: With no strobe and `advance` low, `beat` and the captured start hold their values.
- R6: With `interleave` = 0 (linear), `burst_lo` = (start + beat) mod 4.
- R7: With `interleave` = 1 (interleaved), `burst_lo` = start XOR beat. For example, a start of 1 gives 1, 0, 3, 2.
- R8: An advance taken on beat 3 returns `beat` to 0 and `burst_lo` to the start value.
- R9: `last_beat` is 1 exactly when `beat` is 3.
- R10: `addr_hi_out` equals `addr_hi_in` combinationally, at every moment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strobe_cpu | input | 1 | Processor-side burst start strobe |
| strobe_ctl | input | 1 | Controller-side burst start strobe |
| advance | input | 1 | Step to the next beat |
| interleave | input | 1 | 1 = interleaved order, 0 = linear order |
| start_lo | input | 2 | Low address bits captured at burst start |
| addr_hi_in | input | HI_W | Upper address bits |
| burst_lo | output | 2 | Current low address bits of the burst |
| addr_hi_out | output | HI_W | Upper address bits, passed through |
| beat | output | 2 | Position within the burst (0 to 3) |
| last_beat | output | 1 | High on the fourth beat |

## Verification
The hardest case to reach is a strobe arriving in the same cycle as `advance` in the middle of a running burst. Its effect only shows if the old beat count was not zero and the new start value differs from the old one. The stimulus therefore first advances a burst to beat 2. It then strobes with `advance` still high and a different start value, and checks that the sequence restarts instead of stepping to beat 3. The sweep covers all four start values in both orders and wraps each burst past its fourth beat. It also swaps which strobe opens the burst.

// File: rtl/burst_seq.sv
module burst_seq #(
  parameter int HI_W = 15
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            strobe_cpu,
  input  logic            strobe_ctl,
  input  logic            advance,
  input  logic            interleave,
  input  logic [1:0]      start_lo,
  input  logic [HI_W-1:0] addr_hi_in,
  output logic [1:0]      burst_lo,
  output logic [HI_W-1:0] addr_hi_out,
  output logic [1:0]      beat,
  output logic            last_beat
);

  logic [1:0] start_q;
  logic [1:0] beat_q;
  wire        load = strobe_cpu | strobe_ctl;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_q <= 2'd0;
      beat_q  <= 2'd0;
    end else if (load) begin
      start_q <= start_lo;
      beat_q  <= 2'd0;
    end else if (advance) begin
      beat_q  <= beat_q + 2'd1;
    end
  end

  assign burst_lo    = interleave ? (start_q ^ beat_q) : (start_q + beat_q);
  assign beat        = beat_q;
  assign last_beat   = &beat_q;
  assign addr_hi_out = addr_hi_in;

endmodule

module burst_seq_chk #(
  parameter int HI_W = 15
) (
  input logic            clk,
  input logic            rst_n,
  input logic            strobe_cpu,
  input logic            strobe_ctl,
  input logic            advance,
  input logic            interleave,
  input logic [1:0]      start_lo,
  input logic [HI_W-1:0] addr_hi_in,
  input logic [1:0]      burst_lo,
  input logic [HI_W-1:0] addr_hi_out,
  input logic [1:0]      beat,
  input logic            last_beat
);

  assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_cpu || strobe_ctl) |=> (beat == 2'd0 && burst_lo == $past(start_lo)));

  assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe_cpu && !strobe_ctl && advance) |=> (beat == $past(beat) + 2'd1));

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe_cpu && !strobe_ctl && !advance) |=> $stable(beat));

  assert_linear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe_cpu && !strobe_ctl && advance && !interleave) ##1 !interleave
      |-> (burst_lo == $past(burst_lo) + 2'd1));

  assert_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe_cpu && !strobe_ctl && advance && beat == 2'd3) |=> (beat == 2'd0));

  assert_last_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe_cpu && !strobe_ctl && advance && beat == 2'd2) |=> last_beat);

  always_comb assert_pass_R10: assert (addr_hi_out == addr_hi_in);

endmodule

bind burst_seq burst_seq_chk #(.HI_W(HI_W)) u_chk (.*);

// File: tb/sim_burst_seq.sv
module sim_burst_seq;
  localparam int HI_W = 15;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            strobe_cpu = 1'b0, strobe_ctl = 1'b0, advance = 1'b0, interleave = 1'b0;
  logic [1:0]      start_lo = 2'd0;
  logic [HI_W-1:0] addr_hi_in = '0;
  logic [1:0]      burst_lo, beat;
  logic [HI_W-1:0] addr_hi_out;
  logic            last_beat;

  int checks = 0, failures = 0;
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  burst_seq #(.HI_W(HI_W)) u0 (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  function automatic int addr_of(input int s, input int b, input int il);
    return il ? (s ^ b) : ((s + b) % 4);
  endfunction

  initial begin
    #200000;
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    cyc(); cyc();
    chk("R1 beat", beat, 0); chk("R1 addr", burst_lo, 0); chk("R1 last", last_beat, 0);
    rst_n = 1'b1;
    cyc();
    chk("R1 beat after release", beat, 0); chk("R1 addr after release", burst_lo, 0);

    for (int il = 0; il < 2; il++) begin
      for (int s = 0; s < 4; s++) begin
        for (int which = 0; which < 3; which++) begin
          interleave = il[0];
          start_lo = s[1:0];
          strobe_cpu = (which != 1);
          strobe_ctl = (which != 0);
          advance = 1'b0;
          cyc();
          strobe_cpu = 1'b0; strobe_ctl = 1'b0;
          start_lo = ~s[1:0];
          chk("R2 beat", beat, 0);
          chk("R2 addr", burst_lo, s);
          advance = 1'b1;
          for (int k = 1; k <= 8; k++) begin
            cyc();
            chk("R3 beat", beat, k % 4);
            chk(il ? "R7 interleave" : "R6 linear", burst_lo, addr_of(s, k % 4, il));
            chk("R9 last", last_beat, (k % 4) == 3);
            if (k % 4 == 0) chk("R8 wrap", burst_lo, s);
          end
          advance = 1'b0;
          cyc();
          chk("R5 hold", beat, 0);
        end
      end
    end

    interleave = 1'b0; start_lo = 2'd1; strobe_cpu = 1'b1;
    cyc(); strobe_cpu = 1'b0; advance = 1'b1;
    cyc(); cyc();
    chk("R3 mid", beat, 2);
    start_lo = 2'd3; strobe_ctl = 1'b1;
    cyc(); strobe_ctl = 1'b0; advance = 1'b0;
    chk("R4 beat", beat, 0); chk("R4 addr", burst_lo, 3);
    advance = 1'b1; cyc(); advance = 1'b0;
    for (int k = 0; k < 3; k++) begin
      cyc();
      chk("R5 beat", beat, 1); chk("R5 addr", burst_lo, 0);
    end

    for (int v = 0; v < 8; v++) begin
      addr_hi_in = HI_W'(v * 4099 + 17);
      #1;
      chk("R10 pass", addr_hi_out, v * 4099 + 17);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule